// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital timing controller for a single successive-approximation converter. Two programmable dividers turn the source clock into a control-clock tick and a slower conversion-clock tick. A conversion starts in one of three ways: a hardware trigger, a software convert request, or a software hold bit that parks the sampling switch. The block then walks the bit-decision steps, most significant first, at 6, 8, 10 or 12 bits of resolution. The analog comparator is modelled as a single input bit, which is sampled on each conversion-clock tick.

The block raises an early pulse a programmable number of conversion clocks before the last decision, so that software can start reacting before the data is ready. A one-clock valid pulse marks the final step. An override input chooses which of these two pulses reaches the interrupt line. All timing is derived from clock enables, so the whole block runs on the source clock.

The controller has three states. **IDLE** waits for a start. **SAMPLE** keeps the sampling switch closed. **CONVERT** makes one decision per conversion-clock tick. The transitions are:
- **IDLE to SAMPLE** on the hold bit, or on a hardware trigger.
- **IDLE to CONVERT** on a software request while hold is clear.
- **SAMPLE to SAMPLE** while hold is set. A hardware trigger in this state restarts the sample count.
- **SAMPLE to CONVERT** on a software request, or when the sample count expires.
- **CONVERT to IDLE** on the final decision.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset all outputs are 0: sample_on, conv_active, step_stb, result, result_valid, early_pulse and irq.
- R2: Control-clock code 0 passes every source clock through. Code n from 1 to 63 gives one control tick every 2n source clocks.
- R3: Conversion-clock code m from 1 to 127 gives one conversion tick every 2m control ticks. The reserved code 0 behaves as code 1.
- R4: A hardware trigger in IDLE closes the sampling switch for samp_time conversion clocks, then conversion starts. A samp_time of 0 acts as 1. Because the trigger arrives at an arbitrary phase, sample_on lasts between (S-1)*P+1 and S*P source clocks, where P is the conversion-clock period.
- R5: A conversion makes exactly N decision steps, one per conversion tick. N is set by res_sel, which is captured when conversion starts: 2'b00 = 12 bits, 2'b01 = 10, 2'b10 = 8, 2'b11 = 6.
- R6: The decision at step j (counting from 0) writes comp_in to result bit N-1-j. Result bits at N and above read 0. result_valid is high for one clock together with the final step strobe, and the result holds its value until the next conversion starts.
- R7: While samp_hold is 1, the block stays in SAMPLE, ignores the sample count, and ignores software convert requests.
- R8: With samp_hold at 0, a one-clock conv_req in IDLE or SAMPLE starts a conversion at once.
- R9: A hardware trigger during a conversion is ignored. The conversion runs to its end and the block returns to IDLE without sampling again.
- R10: Early code k makes early_pulse fire together with the strobe of step N-2-k, which is k+1 conversion clocks before the final step.
- R11: An early code above the limit for the captured resolution is treated as that limit. The limit is 7 at 12 and 10 bits, 5 at 8 bits, and 3 at 6 bits.
- R12: With irq_ovr at 1, irq equals result_valid AND done_ien. With irq_ovr at 0, irq equals early_pulse AND early_ien.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tq_code | input | 6 | Control-clock divider code |
| tad_code | input | 7 | Conversion-clock divider code |
| res_sel | input | 2 | Resolution select |
| samp_time | input | 10 | Sample length in conversion clocks |
| early_code | input | 3 | Early-pulse lead code |
| samp_hold | input | 1 | Software hold of the sampling switch |
| conv_req | input | 1 | Software convert request |
| hw_trig | input | 1 | Hardware trigger |
| comp_in | input | 1 | Comparator decision bit |
| done_ien | input | 1 | Completion interrupt enable |
| early_ien | input | 1 | Early interrupt enable |
| irq_ovr | input | 1 | Interrupt source override |
| sample_on | output | 1 | Sampling switch closed |
| conv_active | output | 1 | Conversion in progress |
| step_stb | output | 1 | One-clock strobe per decision step |
| result | output | 12 | Converted value |
| result_valid | output | 1 | Final step, result complete |
| early_pulse | output | 1 | Early data-ready pulse |
| irq | output | 1 | Selected interrupt pulse |

## Verification
A wrong bit counter or a wrong captured resolution shows up within one conversion: the number of strobes, the position of the early pulse, or the value the result holds will differ from what the bench expects. A divider fault shows up as a changed spacing between strobes, and this is visible by the second strobe. A fault in the next-state logic appears within a few clocks as one of three symptoms: sample_on that does not stay high under hold, strobes that appear while the block should be waiting, or a second sample phase after a trigger that arrived during a conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2
    } seq_state_t;

    localparam int RES_MAX = 12;
    localparam int IDX_W   = 4;
    localparam int EI_W    = 3;

    // number of decision steps for a resolution code
    function automatic logic [IDX_W-1:0] res_bits(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return IDX_W'(12);
            2'b01:   return IDX_W'(10);
            2'b10:   return IDX_W'(8);
            default: return IDX_W'(6);
        endcase
    endfunction

    // largest legal early lead code for a resolution code
    function automatic logic [EI_W-1:0] early_limit(input logic [1:0] sel);
        unique case (sel)
            2'b00, 2'b01: return EI_W'(7);
            2'b10:        return EI_W'(5);
            default:      return EI_W'(3);
        endcase
    endfunction

    function automatic logic [EI_W-1:0] clamp_early(input logic [EI_W-1:0] code,
                                                    input logic [1:0] sel);
        logic [EI_W-1:0] lim;
        lim = early_limit(sel);
        return (code > lim) ? lim : code;
    endfunction

endpackage

// File: rtl/sar_div_en.sv
module sar_div_en #(
    parameter int CODE_W      = 6,
    parameter bit ZERO_BYPASS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [CODE_W-1:0] code,
    output logic              tick_out
);
    localparam int CNT_W = CODE_W + 1;

    logic [CODE_W-1:0] eff_code;
    logic [CNT_W-1:0]  lim;
    logic [CNT_W-1:0]  cnt_q;
    logic              wrap;

    assign eff_code = (code == '0) ? CODE_W'(1) : code;
    assign lim      = {eff_code, 1'b0} - CNT_W'(1);
    assign wrap     = (cnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_in) begin
            cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
        end
    end

    generate
        if (ZERO_BYPASS) begin : g_bypass
            assign tick_out = (code == '0) ? tick_in : (tick_in && wrap);
        end else begin : g_plain
            assign tick_out = tick_in && wrap;
        end
    endgenerate

endmodule

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int SAMP_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tad_en,
    input  logic                 samp_hold,
    input  logic                 conv_req,
    input  logic                 hw_trig,
    input  logic [SAMP_W-1:0]    samp_time,
    input  logic [1:0]           res_sel,
    input  logic [EI_W-1:0]      early_code,
    input  logic                 comp_in,
    output logic                 sample_on,
    output logic                 conv_active,
    output logic                 step_stb,
    output logic [RES_MAX-1:0]   result,
    output logic                 result_valid,
    output logic                 early_pulse
);
    seq_state_t st_q, st_d;

    logic [SAMP_W-1:0]  samp_cnt_q;
    logic [SAMP_W-1:0]  samp_tgt;
    logic [SAMP_W:0]    samp_next;
    logic [IDX_W-1:0]   bit_cnt_q;
    logic [IDX_W-1:0]   bits_q;
    logic [IDX_W-1:0]   res_idx;
    logic [IDX_W-1:0]   early_at;
    logic [1:0]         res_q;
    logic [EI_W-1:0]    ek_q;
    logic               samp_done;
    logic               last_step;
    logic               conv_start;

    logic               step_q;
    logic               valid_q;
    logic               early_q;
    logic [RES_MAX-1:0] result_q;

    assign samp_tgt   = (samp_time == '0) ? SAMP_W'(1) : samp_time;
    assign samp_next  = {1'b0, samp_cnt_q} + (SAMP_W+1)'(1);
    assign samp_done  = tad_en && (samp_next >= {1'b0, samp_tgt});
    assign bits_q     = res_bits(res_q);
    assign last_step  = tad_en && (bit_cnt_q == bits_q - IDX_W'(1));
    assign res_idx    = bits_q - IDX_W'(1) - bit_cnt_q;
    assign early_at   = bits_q - IDX_W'(2) - {1'b0, ek_q};
    assign conv_start = (st_q != ST_CONVERT) && (st_d == ST_CONVERT);

    // next-state decision
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (samp_hold)      st_d = ST_SAMPLE;
                else if (conv_req)  st_d = ST_CONVERT;
                else if (hw_trig)   st_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (samp_hold)      st_d = ST_SAMPLE;
                else if (conv_req)  st_d = ST_CONVERT;
                else if (samp_done && !hw_trig) st_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (last_step)      st_d = ST_IDLE;
            end
            default:                st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // sample and bit counters, captured conversion settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_cnt_q <= '0;
            bit_cnt_q  <= '0;
            res_q      <= 2'b00;
            ek_q       <= '0;
        end else begin
            if (st_q != ST_SAMPLE || samp_hold || hw_trig)
                samp_cnt_q <= '0;
            else if (tad_en)
                samp_cnt_q <= samp_next[SAMP_W-1:0];

            if (conv_start) begin
                bit_cnt_q <= '0;
                res_q     <= res_sel;
                ek_q      <= clamp_early(early_code, res_sel);
            end else if (st_q == ST_CONVERT && tad_en) begin
                bit_cnt_q <= bit_cnt_q + IDX_W'(1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= 1'b0;
            valid_q  <= 1'b0;
            early_q  <= 1'b0;
            result_q <= '0;
        end else begin
            step_q  <= (st_q == ST_CONVERT) && tad_en;
            valid_q <= (st_q == ST_CONVERT) && last_step;
            early_q <= (st_q == ST_CONVERT) && tad_en && (bit_cnt_q == early_at);
            if (conv_start)
                result_q <= '0;
            else if (st_q == ST_CONVERT && tad_en)
                result_q[res_idx] <= comp_in;
        end
    end

    assign sample_on    = (st_q == ST_SAMPLE);
    assign conv_active  = (st_q == ST_CONVERT);
    assign step_stb     = step_q;
    assign result_valid = valid_q;
    assign early_pulse  = early_q;
    assign result       = result_q;

    // R5: a decision strobe only follows a cycle spent converting
    a_r5_step_in_convert: assert property (@(posedge clk) disable iff (!rst_n)
        step_q |-> $past(st_q == ST_CONVERT));

    // R6: valid pulse coincides with a decision strobe
    a_r6_valid_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> step_q);

    // R6: result is stable while idle and no conversion is starting
    a_r6_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && st_d != ST_CONVERT) |=> $stable(result_q));

    // R7: hold keeps the switch closed
    a_r7_hold_keeps_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SAMPLE && samp_hold) |=> (st_q == ST_SAMPLE));

    // R9: nothing but a conversion tick leaves the convert state
    a_r9_convert_until_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONVERT && !tad_en) |=> (st_q == ST_CONVERT));

    // R10: early pulse lands on a strobe before the final one
    a_r10_early_before_end: assert property (@(posedge clk) disable iff (!rst_n)
        early_q |-> (step_q && !valid_q));

endmodule

// File: rtl/sar_irq_sel.sv
module sar_irq_sel (
    input  logic irq_ovr,
    input  logic done_ien,
    input  logic early_ien,
    input  logic result_valid,
    input  logic early_pulse,
    output logic irq
);
    always_comb begin
        if (irq_ovr) irq = result_valid && done_ien;
        else         irq = early_pulse && early_ien;
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int TQ_CODE_W  = 6,
    parameter int TAD_CODE_W = 7,
    parameter int SAMP_W     = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [TQ_CODE_W-1:0]  tq_code,
    input  logic [TAD_CODE_W-1:0] tad_code,
    input  logic [1:0]            res_sel,
    input  logic [SAMP_W-1:0]     samp_time,
    input  logic [EI_W-1:0]       early_code,
    input  logic                  samp_hold,
    input  logic                  conv_req,
    input  logic                  hw_trig,
    input  logic                  comp_in,
    input  logic                  done_ien,
    input  logic                  early_ien,
    input  logic                  irq_ovr,
    output logic                  sample_on,
    output logic                  conv_active,
    output logic                  step_stb,
    output logic [RES_MAX-1:0]    result,
    output logic                  result_valid,
    output logic                  early_pulse,
    output logic                  irq
);
    logic tq_en;
    logic tad_en;

    sar_div_en #(.CODE_W(TQ_CODE_W), .ZERO_BYPASS(1'b1)) u_tq_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (1'b1),
        .code     (tq_code),
        .tick_out (tq_en)
    );

    sar_div_en #(.CODE_W(TAD_CODE_W), .ZERO_BYPASS(1'b0)) u_tad_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_in  (tq_en),
        .code     (tad_code),
        .tick_out (tad_en)
    );

    sar_seq_fsm #(.SAMP_W(SAMP_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tad_en       (tad_en),
        .samp_hold    (samp_hold),
        .conv_req     (conv_req),
        .hw_trig      (hw_trig),
        .samp_time    (samp_time),
        .res_sel      (res_sel),
        .early_code   (early_code),
        .comp_in      (comp_in),
        .sample_on    (sample_on),
        .conv_active  (conv_active),
        .step_stb     (step_stb),
        .result       (result),
        .result_valid (result_valid),
        .early_pulse  (early_pulse)
    );

    sar_irq_sel u_irq (
        .irq_ovr      (irq_ovr),
        .done_ien     (done_ien),
        .early_ien    (early_ien),
        .result_valid (result_valid),
        .early_pulse  (early_pulse),
        .irq          (irq)
    );

    // R3: a conversion tick is always also a control tick
    a_r3_tad_within_tq: assert property (@(posedge clk) disable iff (!rst_n)
        tad_en |-> tq_en);

endmodule

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  tq_code = '0;
    logic [6:0]  tad_code = 7'd1;
    logic [1:0]  res_sel = 2'b00;
    logic [9:0]  samp_time = 10'd4;
    logic [2:0]  early_code = '0;
    logic        samp_hold = 1'b0;
    logic        conv_req = 1'b0;
    logic        hw_trig = 1'b0;
    logic        comp_in = 1'b0;
    logic        done_ien = 1'b0;
    logic        early_ien = 1'b0;
    logic        irq_ovr = 1'b0;
    logic        sample_on, conv_active, step_stb, result_valid, early_pulse, irq;
    logic [11:0] result;

    int n_chk = 0;
    int n_err = 0;

    int r_strobes, r_early, r_valid, r_period, r_irq, r_after_steps, r_after_samp, r_after_irq;
    logic [11:0] r_got;

    always #4 clk = ~clk;

    sar_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .tq_code(tq_code), .tad_code(tad_code),
        .res_sel(res_sel), .samp_time(samp_time), .early_code(early_code),
        .samp_hold(samp_hold), .conv_req(conv_req), .hw_trig(hw_trig),
        .comp_in(comp_in), .done_ien(done_ien), .early_ien(early_ien),
        .irq_ovr(irq_ovr), .sample_on(sample_on), .conv_active(conv_active),
        .step_stb(step_stb), .result(result), .result_valid(result_valid),
        .early_pulse(early_pulse), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
        end
    endtask

    function automatic int exp_bits(input logic [1:0] rs);
        case (rs)
            2'b00:   return 12;
            2'b01:   return 10;
            2'b10:   return 8;
            default: return 6;
        endcase
    endfunction

    function automatic int exp_early(input logic [1:0] rs, input int k);
        int lim;
        lim = (rs == 2'b10) ? 5 : ((rs == 2'b11) ? 3 : 7);
        if (k > lim) k = lim;
        return exp_bits(rs) - 2 - k;
    endfunction

    // drives one conversion by software request, feeding comparator bits MSB first
    task automatic run_conv(input logic [1:0] rs, input logic [11:0] code,
                            input logic [2:0] k, input int trig_at);
        int nb, seen, t, last_t;
        nb = exp_bits(rs);
        res_sel = rs;
        early_code = k;
        comp_in = code[nb-1];
        r_early = -1; r_valid = -1; r_period = -1; r_irq = -1;
        r_after_steps = 0; r_after_samp = 0; r_after_irq = 0; r_got = '0;
        @(negedge clk) conv_req = 1'b1;
        @(negedge clk) conv_req = 1'b0;
        seen = 0; t = 0; last_t = 0;
        while (seen < nb && t < 4000) begin
            @(negedge clk);
            t++;
            hw_trig = 1'b0;
            if (irq) r_irq = seen;
            if (step_stb) begin
                if (seen > 0) r_period = t - last_t;
                last_t = t;
                if (early_pulse) r_early = seen;
                if (result_valid) begin
                    r_valid = seen;
                    r_got = result;
                end
                seen++;
                if (seen < nb) comp_in = code[nb-1-seen];
                if (seen == trig_at) hw_trig = 1'b1;
            end
        end
        r_strobes = seen;
        repeat (30) begin
            @(negedge clk);
            hw_trig = 1'b0;
            if (step_stb) r_after_steps++;
            if (sample_on) r_after_samp++;
            if (irq) r_after_irq++;
        end
    endtask

    task automatic t_reset;
        chk("R1 sample_on", int'(sample_on), 0);
        chk("R1 conv_active", int'(conv_active), 0);
        chk("R1 step_stb", int'(step_stb), 0);
        chk("R1 result_valid", int'(result_valid), 0);
        chk("R1 early_pulse", int'(early_pulse), 0);
        chk("R1 irq", int'(irq), 0);
        chk("R1 result", int'(result), 0);
    endtask

    task automatic t_convert(input logic [1:0] rs, input logic [11:0] code, input logic [2:0] k);
        int nb;
        logic [11:0] mask;
        nb = exp_bits(rs);
        mask = 12'((1 << nb) - 1);
        run_conv(rs, code, k, -1);
        chk("R5 step count", r_strobes, nb);
        chk("R6 result value", int'(r_got), int'(code & mask));
        chk("R6 valid on final step", r_valid, nb - 1);
        chk("R10 R11 early step", r_early, exp_early(rs, int'(k)));
        chk("R6 result held", int'(result), int'(code & mask));
        chk("R5 no steps after end", r_after_steps, 0);
    endtask

    task automatic t_divider(input int tq, input int tad, input int period, input string tag);
        tq_code = 6'(tq);
        tad_code = 7'(tad);
        repeat (4) @(negedge clk);
        run_conv(2'b11, 12'h015, 3'd0, -1);
        chk(tag, r_period, period);
        chk("R5 step count at divider", r_strobes, 6);
    endtask

    task automatic t_sample(input int s, input int lo, input int hi);
        int d, g;
        tq_code = '0; tad_code = 7'd1; samp_time = 10'(s); comp_in = 1'b0;
        res_sel = 2'b11;
        @(negedge clk) hw_trig = 1'b1;
        @(negedge clk) hw_trig = 1'b0;
        d = 0;
        while (sample_on && d < 5000) begin
            d++;
            @(negedge clk);
        end
        chk_rng("R4 sample length", d, lo, hi);
        g = 0;
        while (!result_valid && g < 500) begin
            g++;
            @(negedge clk);
        end
        chk("R4 conversion follows sampling", int'(result_valid), 1);
        repeat (10) @(negedge clk);
    endtask

    task automatic t_hold;
        int on_cnt, steps;
        tq_code = '0; tad_code = 7'd1; samp_time = 10'd1000;
        @(negedge clk) samp_hold = 1'b1;
        on_cnt = 0; steps = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sample_on) on_cnt++;
            if (step_stb) steps++;
            conv_req = (i == 20);
        end
        conv_req = 1'b0;
        chk("R7 switch held", on_cnt, 60);
        chk("R7 request ignored under hold", steps, 0);
        samp_hold = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 timed sampling after release", int'(sample_on), 1);
        run_conv(2'b10, 12'h0B9, 3'd1, -1);
        chk("R8 request ends sampling", int'(r_got), 'hB9);
        chk("R8 step count", r_strobes, 8);
    endtask

    task automatic t_trig_ignore;
        run_conv(2'b00, 12'h3C7, 3'd3, 3);
        chk("R9 steps with trigger", r_strobes, 12);
        chk("R9 no resample", r_after_samp, 0);
        chk("R9 no extra steps", r_after_steps, 0);
        chk("R9 result", int'(r_got), 'h3C7);
    endtask

    task automatic t_irq;
        irq_ovr = 1'b0; early_ien = 1'b1; done_ien = 1'b0;
        run_conv(2'b01, 12'h155, 3'd2, -1);
        chk("R12 early source", r_irq, exp_early(2'b01, 2));
        irq_ovr = 1'b1; done_ien = 1'b1;
        run_conv(2'b01, 12'h2AA, 3'd2, -1);
        chk("R12 completion source", r_irq, 9);
        irq_ovr = 1'b0; early_ien = 1'b0;
        run_conv(2'b01, 12'h0F0, 3'd2, -1);
        chk("R12 early disabled", r_irq, -1);
        chk("R12 no stray irq", r_after_irq, 0);
        done_ien = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_convert(2'b00, 12'hA5C, 3'd2);
        t_convert(2'b01, 12'h2B3, 3'd7);
        t_convert(2'b10, 12'h0C6, 3'd7);
        t_convert(2'b11, 12'h02D, 3'd6);
        t_convert(2'b00, 12'hFFF, 3'd0);
        t_convert(2'b00, 12'h000, 3'd7);
        t_convert(2'b11, 12'hFEA, 3'd3);
        t_divider(0, 1, 2, "R2 code0 bypass");
        t_divider(1, 1, 4, "R2 control divide by 2");
        t_divider(3, 2, 24, "R2 R3 combined divide");
        t_divider(0, 5, 10, "R3 conversion divide by 10");
        t_divider(0, 0, 2, "R3 reserved code");
        t_sample(5, 9, 10);
        t_sample(0, 1, 2);
        t_hold();
        t_trig_ignore();
        t_irq();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule